// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block holds wall-clock time and calendar date as packed BCD digits: seconds, minutes, hours, day of week, day of month, month and a two-digit year covering 2000 to 2099. It runs on a 32.768 kHz clock. A one-cycle `tick_1hz` enable advances the seconds. Carries into the higher fields are applied one cycle later. During that cycle `busy` is high and the write port refuses transfers.

The host picks 12-hour or 24-hour presentation with `fmt_24h`. The PM flag is always valid, whichever format is selected. A 30-second rounding request sets the seconds to zero and adds a minute when the seconds were 30 or more. Its status flag clears itself after a fixed number of clock cycles.

A counter reset input returns every field to its initial value. A valid/ready write port loads a complete time and date in one transfer. `wr_valid` may be raised at any time and held. A transfer happens on each rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while `busy` is high. The read fields are plain outputs and are meaningful whenever `busy` is low. Field values written through the port must be legal BCD for their field; they are not checked.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields are year 00, month 01, day 01, minute 00, second 00 and day of week 0. The hour reads 12 with PM 0 in 12-hour mode, or 00 in 24-hour mode. `busy` and `adj_active` are 0.
- R2: A tick increments the seconds in BCD, so 09 becomes 10. A tick at second 59 gives second 00 on the next edge, and `busy` is 1 for exactly the cycle that follows.
- R3: The carry out of the seconds updates the minutes one edge after the seconds. From there it ripples through hours, day, month and year, with year 99 wrapping to 00. `busy` is never high for two cycles in a row.
- R4: `fmt_24h` = 1 selects 24-hour hours 00..23. `fmt_24h` = 0 selects 12-hour hours in the order 12, 01, 02 … 11, and PM changes as 11 rolls over to 12.
- R5: PM is 1 exactly for the times 12:00 to 23:59, including when 24-hour format is selected.
- R6: Day of week is a modulo-7 count, 0 = Sunday through 6 = Saturday. It advances when the day of month advances.
- R7: Months 04, 06, 09 and 11 have 30 days, and February has 28 days. February has 29 days when the two-digit year is divisible by 4 (00 counts). All other months have 31 days.
- R8: An accepted `adj_req` sets the seconds to 00 on the next edge.
  - If the seconds were 30..59, a minute is added one edge later, with `busy` high in between.
  - `adj_active` then stays high for 3 cycles and clears itself.
  - Requests made while `adj_active` is high are ignored.
- R9: `cnt_rst` loads the R1 values on the next edge. It overrides writes, ticks, adjustments and a pending carry.
- R10: A write transfer loads all fields on the next edge and takes priority over a tick or an adjustment in the same cycle.
  - In 12-hour mode `wr_hour` is 01..12 with `wr_pm` giving the half of the day.
  - In 24-hour mode `wr_hour` is 00..23 and `wr_pm` is ignored.
  - `wr_ready` is 0 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle enable per second |
| fmt_24h | input | 1 | 1 = 24-hour format, 0 = 12-hour format |
| adj_req | input | 1 | 30-second rounding request |
| cnt_rst | input | 1 | Return all counters to initial values |
| wr_valid | input | 1 | Write data valid |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_sec | input | 8 | Seconds to load (BCD) |
| wr_min | input | 8 | Minutes to load (BCD) |
| wr_hour | input | 8 | Hours to load (BCD, in the selected format) |
| wr_pm | input | 1 | PM bit to load, used in 12-hour mode only |
| wr_dow | input | 3 | Day of week to load |
| wr_day | input | 8 | Day of month to load (BCD) |
| wr_mon | input | 8 | Month to load (BCD) |
| wr_year | input | 8 | Year to load (BCD) |
| rd_sec | output | 8 | Seconds (BCD) |
| rd_min | output | 8 | Minutes (BCD) |
| rd_hour | output | 8 | Hours in the selected format (BCD) |
| rd_pm | output | 1 | PM flag |
| rd_dow | output | 3 | Day of week |
| rd_day | output | 8 | Day of month (BCD) |
| rd_mon | output | 8 | Month (BCD) |
| rd_year | output | 8 | Year (BCD) |
| busy | output | 1 | Carry being applied; counter access refused |
| adj_active | output | 1 | Adjust in progress, clears itself |

## Verification
Writes, counter resets and adjust acceptance show up after one rising edge. A tick also changes the seconds after one edge. Any carry lands in the minutes and higher fields one edge after that, and `busy` is high in between. The 12/24-hour view and the PM flag are combinational from the stored state and the format input. The bench drives every input on the falling edge and samples on a falling edge. That falling edge is placed after exactly as many rising edges as the result needs: one for seconds, writes and resets, two for carried fields. Intermediate checks catch `busy` and the seconds in the cycle between.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;   // always held as 24-hour BCD
    logic [2:0] dow;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } cal_t;

  localparam cal_t CAL_INIT = '{sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 3'd0,
                                day: 8'h01, mon: 8'h01, year: 8'h00};

  localparam logic [7:0] SEC_LAST  = 8'h59;
  localparam logic [7:0] SEC_HALF  = 8'h30;
  localparam logic [7:0] HOUR_LAST = 8'h23;
  localparam logic [7:0] HOUR_NOON = 8'h12;
  localparam logic [2:0] DOW_LAST  = 3'd6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] b);
    logic [3:0] tens;
    tens = 4'(b / 7'd10);
    return {tens, 4'(b - 7'(tens) * 7'd10)};
  endfunction

  // two-digit year divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] year);
    case (mon)
      8'h02:                      return is_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour_to_12(input logic [7:0] h24);
    logic [6:0] b;
    b = bcd2bin(h24);
    if (b == 7'd0)       b = 7'd12;
    else if (b > 7'd12)  b = b - 7'd12;
    return bin2bcd(b);
  endfunction

  function automatic logic [7:0] hour_to_24(input logic [7:0] h12, input logic pm);
    logic [6:0] b;
    b = bcd2bin(h12);
    if (b == 7'd12) b = 7'd0;
    if (pm)         b = b + 7'd12;
    return bin2bcd(b);
  endfunction

endpackage

// File: rtl/rtc_adj_timer.sv
module rtc_adj_timer #(
  parameter int ADJ_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic fire_o,
  output logic active_o
);
  localparam int CW = $clog2(ADJ_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign active_o = (cnt_q != '0);
  assign fire_o   = req_i && !active_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (fire_o)   cnt_q <= CW'(ADJ_CYCLES);
    else if (active_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rtc_sec_stage.sv
module rtc_sec_stage
  import rtc_cal_pkg::*;
(
  input  logic [7:0] sec_i,
  input  logic       tick_i,
  input  logic       adj_i,
  output logic [7:0] sec_o,
  output logic       carry_o
);
  always_comb begin
    sec_o   = sec_i;
    carry_o = 1'b0;
    if (adj_i) begin
      sec_o   = 8'h00;
      carry_o = (sec_i >= SEC_HALF);
    end else if (tick_i) begin
      if (sec_i == SEC_LAST) begin
        sec_o   = 8'h00;
        carry_o = 1'b1;
      end else begin
        sec_o = bcd_inc(sec_i);
      end
    end
  end
endmodule

// File: rtl/rtc_carry_chain.sv
module rtc_carry_chain
  import rtc_cal_pkg::*;
(
  input  cal_t cur_i,
  output cal_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (cur_i.min != SEC_LAST) begin
      nxt_o.min = bcd_inc(cur_i.min);
    end else begin
      nxt_o.min = 8'h00;
      if (cur_i.hour != HOUR_LAST) begin
        nxt_o.hour = bcd_inc(cur_i.hour);
      end else begin
        nxt_o.hour = 8'h00;
        nxt_o.dow  = (cur_i.dow == DOW_LAST) ? 3'd0 : cur_i.dow + 3'd1;
        if (cur_i.day != last_day(cur_i.mon, cur_i.year)) begin
          nxt_o.day = bcd_inc(cur_i.day);
        end else begin
          nxt_o.day = 8'h01;
          if (cur_i.mon != 8'h12) begin
            nxt_o.mon = bcd_inc(cur_i.mon);
          end else begin
            nxt_o.mon  = 8'h01;
            nxt_o.year = (cur_i.year == 8'h99) ? 8'h00 : bcd_inc(cur_i.year);
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADJ_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       fmt_24h,
  input  logic       adj_req,
  input  logic       cnt_rst,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_sec,
  input  logic [7:0] wr_min,
  input  logic [7:0] wr_hour,
  input  logic       wr_pm,
  input  logic [2:0] wr_dow,
  input  logic [7:0] wr_day,
  input  logic [7:0] wr_mon,
  input  logic [7:0] wr_year,
  output logic [7:0] rd_sec,
  output logic [7:0] rd_min,
  output logic [7:0] rd_hour,
  output logic       rd_pm,
  output logic [2:0] rd_dow,
  output logic [7:0] rd_day,
  output logic [7:0] rd_mon,
  output logic [7:0] rd_year,
  output logic       busy,
  output logic       adj_active
);
  cal_t       cal_q;
  cal_t       cal_carried;
  cal_t       cal_loaded;
  logic       busy_q;
  logic       adj_fire;
  logic [7:0] sec_nxt;
  logic       sec_carry;
  logic       wr_fire;

  rtc_adj_timer #(.ADJ_CYCLES(ADJ_CYCLES)) u_adj (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (adj_req),
    .fire_o   (adj_fire),
    .active_o (adj_active)
  );

  rtc_sec_stage u_sec (
    .sec_i   (cal_q.sec),
    .tick_i  (tick_1hz),
    .adj_i   (adj_fire),
    .sec_o   (sec_nxt),
    .carry_o (sec_carry)
  );

  rtc_carry_chain u_chain (
    .cur_i (cal_q),
    .nxt_o (cal_carried)
  );

  assign wr_ready = !busy_q;
  assign wr_fire  = wr_valid && wr_ready;

  always_comb begin
    cal_loaded.sec  = wr_sec;
    cal_loaded.min  = wr_min;
    cal_loaded.hour = fmt_24h ? wr_hour : hour_to_24(wr_hour, wr_pm);
    cal_loaded.dow  = wr_dow;
    cal_loaded.day  = wr_day;
    cal_loaded.mon  = wr_mon;
    cal_loaded.year = wr_year;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= CAL_INIT;
      busy_q <= 1'b0;
    end else if (cnt_rst) begin
      cal_q  <= CAL_INIT;
      busy_q <= 1'b0;
    end else if (wr_fire) begin
      cal_q  <= cal_loaded;
      busy_q <= 1'b0;
    end else begin
      if (busy_q) cal_q <= cal_carried;
      cal_q.sec <= sec_nxt;
      busy_q    <= sec_carry;
    end
  end

  assign busy    = busy_q;
  assign rd_sec  = cal_q.sec;
  assign rd_min  = cal_q.min;
  assign rd_hour = fmt_24h ? cal_q.hour : hour_to_12(cal_q.hour);
  assign rd_pm   = (cal_q.hour >= HOUR_NOON);
  assign rd_dow  = cal_q.dow;
  assign rd_day  = cal_q.day;
  assign rd_mon  = cal_q.mon;
  assign rd_year = cal_q.year;
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk #(
  parameter int ADJ_CYCLES = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       fmt_24h,
  input logic       adj_req,
  input logic       cnt_rst,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_sec,
  input logic [7:0] wr_min,
  input logic [7:0] rd_sec,
  input logic [7:0] rd_min,
  input logic [7:0] rd_hour,
  input logic       rd_pm,
  input logic [2:0] rd_dow,
  input logic [7:0] rd_day,
  input logic [7:0] rd_mon,
  input logic [7:0] rd_year,
  input logic       busy,
  input logic       adj_active
);
  localparam int RUN_W = $clog2(ADJ_CYCLES + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (adj_active) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !adj_req && !wr_valid && !cnt_rst && rd_sec == 8'h59) |=> (busy && rd_sec == 8'h00));

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sec <= 8'h59 && rd_sec[3:0] <= 4'd9));

  // R3
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R4
  hour12_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_24h |-> (rd_hour >= 8'h01 && rd_hour <= 8'h12));

  // R5
  pm_24h_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_24h |-> (rd_pm == (rd_hour >= 8'h12)));

  // R6
  dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dow <= 3'd6);

  // R8
  adj_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_req && !adj_active && !wr_valid && !cnt_rst) |=> (rd_sec == 8'h00 && adj_active));

  // R8
  adj_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adj_active) |-> (run_q == RUN_W'(ADJ_CYCLES)));

  // R8
  adj_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(ADJ_CYCLES));

  // R9
  cnt_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> (rd_sec == 8'h00 && rd_min == 8'h00 && rd_day == 8'h01 && rd_mon == 8'h01 &&
                 rd_year == 8'h00 && rd_dow == 3'd0 && !rd_pm && !busy));

  // R10
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !cnt_rst) |=> (rd_sec == $past(wr_sec) && rd_min == $past(wr_min)));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk #(.ADJ_CYCLES(ADJ_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_1hz   (tick_1hz),
  .fmt_24h    (fmt_24h),
  .adj_req    (adj_req),
  .cnt_rst    (cnt_rst),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_sec     (wr_sec),
  .wr_min     (wr_min),
  .rd_sec     (rd_sec),
  .rd_min     (rd_min),
  .rd_hour    (rd_hour),
  .rd_pm      (rd_pm),
  .rd_dow     (rd_dow),
  .rd_day     (rd_day),
  .rd_mon     (rd_mon),
  .rd_year    (rd_year),
  .busy       (busy),
  .adj_active (adj_active)
);

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;

  typedef struct packed {
    logic       f24;
    logic [7:0] s;
    logic [7:0] m;
    logic [7:0] h;
    logic       p;
    logic [2:0] w;
    logic [7:0] d;
    logic [7:0] mo;
    logic [7:0] y;
  } tv_t;

  typedef struct packed {
    tv_t st;
    tv_t ex;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R2: plain second step
    '{'{1'b1, 8'h05, 8'h00, 8'h00, 1'b0, 3'd0, 8'h01, 8'h01, 8'h00},
      '{1'b1, 8'h06, 8'h00, 8'h00, 1'b0, 3'd0, 8'h01, 8'h01, 8'h00}},
    // R3 R5: minute carry, afternoon in 24h
    '{'{1'b1, 8'h59, 8'h34, 8'h12, 1'b0, 3'd3, 8'h15, 8'h06, 8'h23},
      '{1'b1, 8'h00, 8'h35, 8'h12, 1'b1, 3'd3, 8'h15, 8'h06, 8'h23}},
    // R3 R6: full wrap, year 99 to 00, Saturday to Sunday
    '{'{1'b1, 8'h59, 8'h59, 8'h23, 1'b0, 3'd6, 8'h31, 8'h12, 8'h99},
      '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h01, 8'h01, 8'h00}},
    // R7: leap February 28 -> 29
    '{'{1'b1, 8'h59, 8'h59, 8'h23, 1'b0, 3'd2, 8'h28, 8'h02, 8'h24},
      '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 3'd3, 8'h29, 8'h02, 8'h24}},
    // R7: common February 28 -> March 1
    '{'{1'b1, 8'h59, 8'h59, 8'h23, 1'b0, 3'd2, 8'h28, 8'h02, 8'h23},
      '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 3'd3, 8'h01, 8'h03, 8'h23}},
    // R7: year 00 leap, February 29 -> March 1
    '{'{1'b1, 8'h59, 8'h59, 8'h23, 1'b0, 3'd4, 8'h29, 8'h02, 8'h00},
      '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 3'd5, 8'h01, 8'h03, 8'h00}},
    // R7: 30-day month
    '{'{1'b1, 8'h59, 8'h59, 8'h23, 1'b0, 3'd1, 8'h30, 8'h04, 8'h25},
      '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 3'd2, 8'h01, 8'h05, 8'h25}},
    // R7: 31-day month
    '{'{1'b1, 8'h59, 8'h59, 8'h23, 1'b0, 3'd5, 8'h31, 8'h01, 8'h25},
      '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 3'd6, 8'h01, 8'h02, 8'h25}},
    // R4: 12h 11:59:59 AM -> 12:00:00 PM
    '{'{1'b0, 8'h59, 8'h59, 8'h11, 1'b0, 3'd1, 8'h05, 8'h05, 8'h05},
      '{1'b0, 8'h00, 8'h00, 8'h12, 1'b1, 3'd1, 8'h05, 8'h05, 8'h05}},
    // R4: 12h 12:59:59 PM -> 01:00:00 PM
    '{'{1'b0, 8'h59, 8'h59, 8'h12, 1'b1, 3'd1, 8'h05, 8'h05, 8'h05},
      '{1'b0, 8'h00, 8'h00, 8'h01, 1'b1, 3'd1, 8'h05, 8'h05, 8'h05}},
    // R4 R6: 12h 11:59:59 PM -> 12:00:00 AM next day
    '{'{1'b0, 8'h59, 8'h59, 8'h11, 1'b1, 3'd0, 8'h10, 8'h10, 8'h10},
      '{1'b0, 8'h00, 8'h00, 8'h12, 1'b0, 3'd1, 8'h11, 8'h10, 8'h10}},
    // R5: 24h 11:59:59 -> 12:00:00 with PM set
    '{'{1'b1, 8'h59, 8'h59, 8'h11, 1'b0, 3'd2, 8'h07, 8'h07, 8'h07},
      '{1'b1, 8'h00, 8'h00, 8'h12, 1'b1, 3'd2, 8'h07, 8'h07, 8'h07}},
    // R2: BCD digit carry 09 -> 10
    '{'{1'b1, 8'h09, 8'h09, 8'h09, 1'b0, 3'd4, 8'h09, 8'h09, 8'h09},
      '{1'b1, 8'h10, 8'h09, 8'h09, 1'b0, 3'd4, 8'h09, 8'h09, 8'h09}},
    // R6 R7: August 31 -> September 1, Saturday -> Sunday
    '{'{1'b1, 8'h59, 8'h59, 8'h23, 1'b0, 3'd6, 8'h31, 8'h08, 8'h98},
      '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h01, 8'h09, 8'h98}}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       fmt_24h = 1'b0;
  logic       adj_req = 1'b0;
  logic       cnt_rst = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_sec = '0, wr_min = '0, wr_hour = '0, wr_day = '0, wr_mon = '0, wr_year = '0;
  logic       wr_pm = 1'b0;
  logic [2:0] wr_dow = '0;
  logic [7:0] rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year;
  logic       rd_pm, busy, adj_active;
  logic [2:0] rd_dow;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  rtc_bcd_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .fmt_24h(fmt_24h),
    .adj_req(adj_req), .cnt_rst(cnt_rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_pm(wr_pm),
    .wr_dow(wr_dow), .wr_day(wr_day), .wr_mon(wr_mon), .wr_year(wr_year),
    .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_pm(rd_pm),
    .rd_dow(rd_dow), .rd_day(rd_day), .rd_mon(rd_mon), .rd_year(rd_year),
    .busy(busy), .adj_active(adj_active)
  );

  function automatic tv_t observed();
    return '{fmt_24h, rd_sec, rd_min, rd_hour, rd_pm, rd_dow, rd_day, rd_mon, rd_year};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_time(input tv_t t);
    fmt_24h = t.f24;
    wr_sec = t.s; wr_min = t.m; wr_hour = t.h; wr_pm = t.p;
    wr_dow = t.w; wr_day = t.d; wr_mon = t.mo; wr_year = t.y;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic tick_once();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tv_t ini12, ini24;
    ini12 = '{1'b0, 8'h00, 8'h00, 8'h12, 1'b0, 3'd0, 8'h01, 8'h01, 8'h00};
    ini24 = '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h01, 8'h01, 8'h00};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values, 12-hour view
    check("R1 reset fields", 64'(observed()), 64'(ini12));
    check("R1 busy/adj idle", {62'd0, busy, adj_active}, 64'd0);
    // R1 R4: same state in 24-hour view
    fmt_24h = 1'b1;
    #1;
    check("R1 R4 reset 24h view", 64'(observed()), 64'(ini24));
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7: vector table
    for (int i = 0; i < NV; i++) begin
      write_time(VECS[i].st);
      tick_once();
      @(negedge clk);
      check($sformatf("R2-R7 vector %0d", i), 64'(observed()), 64'(VECS[i].ex));
    end

    // R2 R3 R10: busy lasts one cycle, minutes one edge after seconds
    write_time('{1'b1, 8'h59, 8'h00, 8'h00, 1'b0, 3'd0, 8'h01, 8'h01, 8'h00});
    tick_once();
    check("R2 busy set, sec wrapped", {47'd0, busy, rd_sec, rd_min}, {47'd0, 1'b1, 8'h00, 8'h00});
    check("R10 wr_ready low while busy", 64'(wr_ready), 64'd0);
    @(negedge clk);
    check("R3 busy cleared, minute carried", {55'd0, busy, rd_min}, {55'd0, 1'b0, 8'h01});

    // R10: write beats a tick in the same cycle
    wr_sec = 8'h10; wr_valid = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; tick_1hz = 1'b0;
    check("R10 write over tick", 64'(rd_sec), 64'h10);

    // R10: 12-hour write of 12 AM reads 00 in 24h
    write_time('{1'b0, 8'h20, 8'h30, 8'h12, 1'b0, 3'd2, 8'h03, 8'h03, 8'h03});
    fmt_24h = 1'b1;
    #1;
    check("R10 12h load 12 AM as 00", {55'd0, rd_pm, rd_hour}, {55'd0, 1'b0, 8'h00});
    @(negedge clk);

    // R8: adjust below 30 seconds
    write_time('{1'b1, 8'h29, 8'h10, 8'h05, 1'b0, 3'd2, 8'h03, 8'h03, 8'h03});
    adj_req = 1'b1;
    // R10: write for the next edge, during the adjust window
    wr_sec = 8'h45; wr_min = 8'h10;
    @(negedge clk);
    adj_req = 1'b0;
    check("R8 adj <30 zeroes sec", {46'd0, adj_active, busy, rd_min, rd_sec}, {46'd0, 1'b1, 1'b0, 8'h10, 8'h00});
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    adj_req = 1'b1;
    check("R8 active 2nd cycle", 64'(adj_active), 64'd1);
    @(negedge clk);
    adj_req = 1'b0;
    check("R8 request while active ignored", {55'd0, adj_active, rd_sec}, {55'd0, 1'b1, 8'h45});
    @(negedge clk);
    check("R8 self-clear after 3 cycles", 64'(adj_active), 64'd0);
    check("R8 no minute carry below 30", 64'(rd_min), 64'h10);

    // R8: adjust at 30 seconds and above
    write_time('{1'b1, 8'h30, 8'h10, 8'h05, 1'b0, 3'd2, 8'h03, 8'h03, 8'h03});
    adj_req = 1'b1;
    @(negedge clk);
    adj_req = 1'b0;
    check("R8 adj >=30 zero and busy", {47'd0, busy, rd_min, rd_sec}, {47'd0, 1'b1, 8'h10, 8'h00});
    @(negedge clk);
    check("R8 adj >=30 adds minute", {55'd0, busy, rd_min}, {55'd0, 1'b0, 8'h11});
    repeat (3) @(negedge clk);

    // R9: counter reset
    write_time('{1'b0, 8'h22, 8'h45, 8'h01, 1'b1, 3'd4, 8'h20, 8'h07, 8'h33});
    cnt_rst = 1'b1;
    @(negedge clk);
    cnt_rst = 1'b0;
    check("R9 counter reset", 64'(observed()), 64'(ini12));

    // R9: counter reset cancels a pending carry
    write_time('{1'b1, 8'h59, 8'h20, 8'h10, 1'b0, 3'd1, 8'h02, 8'h02, 8'h02});
    tick_once();
    check("R9 carry pending before reset", 64'(busy), 64'd1);
    cnt_rst = 1'b1;
    @(negedge clk);
    cnt_rst = 1'b0;
    check("R9 reset during busy", {47'd0, busy, rd_hour, rd_min}, {47'd0, 1'b0, 8'h00, 8'h00});
    @(negedge clk);
    check("R9 carry dropped", {55'd0, busy, rd_min}, {55'd0, 1'b0, 8'h00});

    summary();
    $finish;
  end
endmodule